// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five software localities currently owns a shared secure-module register interface. Every locality sees its own 4 KB window on a simple synchronous register bus, chosen by address bits [15:12], and each window holds a one-byte access register at offset 0x000. A locality asks for ownership by setting the request bit of its own access register, gives ownership back by writing the active bit, and confirms that it owns the interface by reading a value with both the valid and the active bits set. Requests made while another locality owns the interface wait as pending and are handed over when the owner lets go.

The arbitration core is a two-state machine. `ST_IDLE` means nobody owns the interface; `ST_OWNED` means exactly one locality does. Transitions: `GRANT` (ST_IDLE to ST_OWNED, on a request or a waiting request), `HANDOVER` (ST_OWNED to ST_OWNED with a new owner, when the owner releases while others wait), `RELEASE` (ST_OWNED to ST_IDLE, when the owner releases and nobody waits) and `HOLD` (no change of owner; new requests from non-owners are queued). Every change of owner raises a one-cycle change event for the interrupt logic. The block also passes on a write strobe for owner-only registers at other offsets, asserted only when the writing locality owns the interface.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality owns the interface, `owner_valid` and `loc_change` are 0, no request is stored, and `fwd_wr` is 0.
- R2: A read of offset 0x000 in window 0..4 returns, one cycle later on `rd_data`, a byte with bit 7 always 1 (valid), bit 5 set when that locality owns the interface, bit 2 set when any locality has a request waiting, bit 1 set when that locality's own request is waiting; all other bits are 0.
- R3: In ST_IDLE, a write of bit 1 = 1 to the access register of locality L (byte enable 0 set) makes L the owner at that same clock edge (GRANT), with no request left stored for L.
- R4: When the owner releases while several localities wait, the highest-numbered waiting locality becomes owner at that edge (HANDOVER) and only its request is cleared.
- R5: In ST_OWNED, a request from a non-owner leaves the owner unchanged and makes bit 2 read as 1 in every window, including the owner's.
- R6: A write of bit 5 = 1 by the owner with nobody waiting returns the block to ST_IDLE (RELEASE); the access register then reads 0x80.
- R7: A write of bit 5 = 1 from a locality that is not the owner has no effect on ownership.
- R8: `loc_change` is 1 for exactly the one cycle following each edge at which the owner or the owned/free state changes, and 0 otherwise.
- R9: `fwd_wr` is 1 only during a bus write from the current owner to a nonzero offset in its window; writes from other localities, or to offset 0x000, do not raise it.
- R10: Windows 5 to 15 hold no register: a request written there is ignored and a read there returns 0.
- R11: A write whose byte enable 0 is clear does not touch the access register, even with the request bit set in another byte lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 16 | Byte address; [15:12] selects the locality window |
| bus_wdata | input | 32 | Write data; the access register uses byte 0 |
| bus_be | input | 4 | Byte enables for the write data |
| rd_data | output | 32 | Read data, valid the cycle after `bus_rd` |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Number of the owning locality (0 when free) |
| loc_change | output | 1 | One-cycle event on every change of owner |
| fwd_wr | output | 1 | Write strobe for owner-only registers, combinational |

## Verification
Ownership and the change event both update at the clock edge that takes the write, so the bench samples `owner_valid`, `owner_id` and `loc_change` one time unit after that edge, and confirms the event has dropped after the following edge. Read data is registered, so each read task raises `bus_rd`, waits for one edge and samples `rd_data` just after it, seeing the state from before that edge. `fwd_wr` is combinational and is sampled while the write is still on the bus, before the edge that consumes it.

// File: rtl/lar_pkg.sv
package lar_pkg;
    localparam int ACC_W      = 8;
    localparam int BIT_VALID  = 7;
    localparam int BIT_ACTIVE = 5;
    localparam int BIT_PEND   = 2;
    localparam int BIT_REQ    = 1;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/lar_decode.sv
module lar_decode #(
    parameter int ADDR_W  = 16,
    parameter int WIN_LSB = 12,
    parameter int N_LOC   = 5,
    localparam int WIN_W  = ADDR_W - WIN_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIN_W-1:0]  win,
    output logic              in_range,
    output logic              is_access
);
    always_comb begin
        win       = addr[ADDR_W-1:WIN_LSB];
        in_range  = (int'(win) < N_LOC);
        is_access = (addr[WIN_LSB-1:0] == '0);
    end
endmodule

// File: rtl/lar_fsm.sv
module lar_fsm
    import lar_pkg::*;
#(
    parameter int N_LOC = 5,
    localparam int LOC_W = (N_LOC > 1) ? $clog2(N_LOC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr,
    input  logic [LOC_W-1:0] wr_loc,
    input  logic             set_req,
    input  logic             set_rel,
    output logic             owner_valid,
    output logic [LOC_W-1:0] owner_id,
    output logic [N_LOC-1:0] req_q,
    output logic             loc_change
);
    arb_state_e       state_q, state_d;
    logic [LOC_W-1:0] owner_d;
    logic [N_LOC-1:0] req_d;
    logic [N_LOC-1:0] incoming;
    logic [N_LOC-1:0] cand;

    function automatic logic [LOC_W-1:0] pick_hi(input logic [N_LOC-1:0] v);
        logic [LOC_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < N_LOC; i++)
            if (v[i]) idx = LOC_W'(i);
        return idx;
    endfunction

    function automatic logic [N_LOC-1:0] onehot(input logic [LOC_W-1:0] n);
        return N_LOC'(1) << n;
    endfunction

    always_comb begin
        state_d  = state_q;
        owner_d  = owner_id;
        req_d    = req_q;
        cand     = '0;
        incoming = (acc_wr && set_req) ? onehot(wr_loc) : '0;
        unique case (state_q)
            ST_IDLE: begin
                cand = req_q | incoming;
                if (cand != '0) begin                       // GRANT
                    state_d = ST_OWNED;
                    owner_d = pick_hi(cand);
                    req_d   = cand & ~onehot(pick_hi(cand));
                end
            end
            ST_OWNED: begin
                if (acc_wr && set_rel && wr_loc == owner_id) begin
                    cand = req_q;
                    if (cand != '0) begin                   // HANDOVER
                        owner_d = pick_hi(cand);
                        req_d   = cand & ~onehot(pick_hi(cand));
                    end else begin                          // RELEASE
                        state_d = ST_IDLE;
                        owner_d = '0;
                    end
                end else begin                              // HOLD
                    req_d = req_q | (incoming & ~onehot(owner_id));
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            owner_id <= '0;
            req_q    <= '0;
        end else begin
            state_q  <= state_d;
            owner_id <= owner_d;
            req_q    <= req_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            loc_change <= 1'b0;
        else
            loc_change <= (state_d != state_q) || (owner_d != owner_id);
    end

    assign owner_valid = (state_q == ST_OWNED);
endmodule

// File: rtl/lar_rdmux.sv
module lar_rdmux
    import lar_pkg::*;
#(
    parameter int N_LOC  = 5,
    parameter int DATA_W = 32,
    localparam int LOC_W = (N_LOC > 1) ? $clog2(N_LOC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [LOC_W-1:0]  rd_loc,
    input  logic              owner_valid,
    input  logic [LOC_W-1:0]  owner_id,
    input  logic [N_LOC-1:0]  req_q,
    output logic [DATA_W-1:0] rd_data
);
    logic [ACC_W-1:0] acc_view;

    always_comb begin
        acc_view             = '0;
        acc_view[BIT_VALID]  = 1'b1;
        acc_view[BIT_ACTIVE] = owner_valid && (owner_id == rd_loc);
        acc_view[BIT_PEND]   = |req_q;
        acc_view[BIT_REQ]    = req_q[rd_loc];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= rd_hit ? DATA_W'(acc_view) : '0;
    end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
    import lar_pkg::*;
#(
    parameter int N_LOC   = 5,
    parameter int ADDR_W  = 16,
    parameter int WIN_LSB = 12,
    parameter int DATA_W  = 32,
    localparam int BE_W   = DATA_W / 8,
    localparam int LOC_W  = (N_LOC > 1) ? $clog2(N_LOC) : 1,
    localparam int WIN_W  = ADDR_W - WIN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              owner_valid,
    output logic [LOC_W-1:0]  owner_id,
    output logic              loc_change,
    output logic              fwd_wr
);
    logic [WIN_W-1:0] win;
    logic             in_range, is_access, acc_wr, rd_hit;
    logic [LOC_W-1:0] sel_loc;
    logic [N_LOC-1:0] req_q;

    lar_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .N_LOC(N_LOC)) i_dec (
        .addr(bus_addr), .win(win), .in_range(in_range), .is_access(is_access)
    );

    assign sel_loc = win[LOC_W-1:0];
    assign acc_wr  = bus_wr && in_range && is_access && bus_be[0];
    assign rd_hit  = bus_rd && in_range && is_access;
    assign fwd_wr  = bus_wr && in_range && !is_access && owner_valid
                     && (sel_loc == owner_id);

    lar_fsm #(.N_LOC(N_LOC)) i_fsm (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .wr_loc(sel_loc),
        .set_req(bus_wdata[BIT_REQ]), .set_rel(bus_wdata[BIT_ACTIVE]),
        .owner_valid(owner_valid), .owner_id(owner_id),
        .req_q(req_q), .loc_change(loc_change)
    );

    lar_rdmux #(.N_LOC(N_LOC), .DATA_W(DATA_W)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_loc(sel_loc),
        .owner_valid(owner_valid), .owner_id(owner_id),
        .req_q(req_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
    parameter int N_LOC = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [15:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic [31:0] rd_data,
    input logic        owner_valid,
    input logic [2:0]  owner_id,
    input logic        loc_change,
    input logic        fwd_wr
);
    logic acc_w;
    assign acc_w = bus_wr && bus_be[0] && (bus_addr[11:0] == 12'h000)
                   && (int'(bus_addr[15:12]) < N_LOC);

    a_r3_grant_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_valid && acc_w && bus_wdata[1])
        |=> (owner_valid && {1'b0, owner_id} == $past(bus_addr[15:12])));

    a_r7_foreign_release: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && acc_w && bus_wdata[5] && bus_addr[15:12] != {1'b0, owner_id})
        |=> (owner_valid && $stable(owner_id)));

    a_r8_change_event: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (loc_change ==
            ((owner_valid != $past(owner_valid)) || (owner_id != $past(owner_id)))));

    a_r9_fwd_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_wr |-> (owner_valid && bus_wr && bus_addr[15:12] == {1'b0, owner_id}));

    a_r2_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[11:0] == 12'h000 && int'(bus_addr[15:12]) < N_LOC)
        |=> rd_data[7]);

    a_r10_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr[15:12]) >= N_LOC) |=> (rd_data == 32'h0));
endmodule

bind locality_arbiter lar_checker #(.N_LOC(N_LOC)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .rd_data(rd_data), .owner_valid(owner_valid), .owner_id(owner_id),
    .loc_change(loc_change), .fwd_wr(fwd_wr)
);

// File: tb/test_locality_arbiter.sv
`timescale 1ns/1ps
module test_locality_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] rd_data;
    logic        owner_valid, loc_change, fwd_wr;
    logic [2:0]  owner_id;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    locality_arbiter i_locality_arbiter (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .rd_data(rd_data), .owner_valid(owner_valid), .owner_id(owner_id),
        .loc_change(loc_change), .fwd_wr(fwd_wr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int loc, input int off, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1; bus_addr = 16'((loc << 12) | off); bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_wr = 0; bus_wdata = '0; bus_be = '0;
    endtask

    task automatic rd(input int loc, output logic [31:0] d);
        bus_rd = 1; bus_addr = 16'(loc << 12);
        @(posedge clk); #1;
        d = rd_data; bus_rd = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 owner_valid", 32'(owner_valid), 0);
        check("R1 loc_change", 32'(loc_change), 0);
        check("R1 fwd_wr", 32'(fwd_wr), 0);
        rd(0, d); check("R1/R2 idle read loc0", d, 32'h80);
        rd(4, d); check("R2 idle read loc4", d, 32'h80);
    endtask

    task automatic t_grant();
        logic [31:0] d;
        wr(1, 0, 32'h02, 4'h1);
        check("R3 owner_valid", 32'(owner_valid), 1);
        check("R3 owner_id", 32'(owner_id), 1);
        check("R8 grant event", 32'(loc_change), 1);
        rd(1, d); check("R3/R2 owner read", d, 32'hA0);
        check("R8 event one cycle", 32'(loc_change), 0);
        rd(0, d); check("R2 other read", d, 32'h80);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(0, 0, 32'h02, 4'h1);
        wr(3, 0, 32'h02, 4'h1);
        check("R5 owner held", 32'(owner_id), 1);
        check("R8 no event on hold", 32'(loc_change), 0);
        rd(4, d); check("R5 pending in loc4", d, 32'h84);
        rd(3, d); check("R5/R2 own request loc3", d, 32'h86);
        rd(1, d); check("R5 pending seen by owner", d, 32'hA4);
    endtask

    task automatic t_foreign_release();
        wr(3, 0, 32'h20, 4'h1);
        check("R7 owner kept", {28'b0, owner_valid, owner_id}, 32'h9);
        check("R7 no event", 32'(loc_change), 0);
    endtask

    task automatic t_forward();
        bus_wr = 1; bus_addr = 16'h3018; #1;
        check("R9 non-owner blocked", 32'(fwd_wr), 0);
        bus_addr = 16'h1018; #1;
        check("R9 owner forwarded", 32'(fwd_wr), 1);
        bus_addr = 16'h1000; #1;
        check("R9 offset zero not forwarded", 32'(fwd_wr), 0);
        bus_wr = 0; bus_addr = '0;
        @(posedge clk); #1;
    endtask

    task automatic t_handover();
        logic [31:0] d;
        wr(1, 0, 32'h20, 4'h1);
        check("R4 highest wins", {28'b0, owner_valid, owner_id}, 32'hB);
        check("R8 handover event", 32'(loc_change), 1);
        rd(3, d); check("R4 winner cleared, loc0 waits", d, 32'hA4);
        wr(3, 0, 32'h20, 4'h1);
        check("R4 next handover", {28'b0, owner_valid, owner_id}, 32'h8);
        rd(0, d); check("R4 queue empty", d, 32'hA0);
        wr(0, 0, 32'h20, 4'h1);
        check("R6 released", 32'(owner_valid), 0);
        check("R8 release event", 32'(loc_change), 1);
        rd(0, d); check("R6 idle read", d, 32'h80);
    endtask

    task automatic t_window();
        logic [31:0] d;
        wr(7, 0, 32'h02, 4'h1);
        check("R10 window 7 ignored", 32'(owner_valid), 0);
        check("R10 no event", 32'(loc_change), 0);
        rd(7, d); check("R10 read window 7", d, 32'h0);
    endtask

    task automatic t_lanes();
        logic [31:0] d;
        wr(2, 0, 32'h02, 4'hE);
        check("R11 lane 0 disabled", 32'(owner_valid), 0);
        wr(2, 0, 32'h0200, 4'h2);
        check("R11 request in lane 1", 32'(owner_valid), 0);
        rd(2, d); check("R11 no request stored", d, 32'h80);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_grant();
        t_pending();
        t_foreign_release();
        t_forward();
        t_handover();
        t_window();
        t_lanes();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule